// File: doc/BRIEF.md
# Two-Wire EEPROM Slave with Write Guard

This block is the slave side of a two-wire serial EEPROM, with a small byte array held in registers. The block runs on its own system clock. It oversamples the clock and data lines of the bus, recognises start and stop conditions, and shifts 8-bit frames, each followed by a ninth acknowledge bit. The data line is open-drain, so the block only pulls it low, through `sda_drive_o`. Masters can set the word pointer and read at random, read sequentially, and write a page of up to `PAGE` bytes.

Writes to the array are guarded in several ways. A write is committed only when three things hold: every acknowledge in the sequence was good, the stop arrives after a whole number of 9-clock frames, and the write-enable pin is high. A timer stands in for the self-timed programming cycle. While that cycle runs, the block does not acknowledge its address, so a master can poll to find out when the write is done. Dropping the write-enable pin during the cycle aborts it. A protection byte, written through a second device code, sets a boundary. Array writes at or above that boundary are dropped, and the boundary can never go below half the array.

Top module: `e2_write_guard`

## Requirements
- R1: After reset the block leaves the data line released. A start is a falling data line while the clock line is high, and a stop is a rising data line while the clock line is high.
- R2: The control byte is {code[3:0], sel[2:0], rw} with rw=1 meaning read. The block acknowledges (pulls data low on the ninth clock) only when code is 4'b1010 (array) or 4'b1011 (protection byte) and sel equals `DEV_SEL`. Any other control byte gets no acknowledge.
- R3: A random read works as follows. An array-write control byte is followed by one word-address byte, whose low log2(DEPTH) bits set the pointer. A repeated start and an array-read control byte then return the byte stored at that address.
- R4: A sequential read returns consecutive addresses while the master acknowledges each byte, and it wraps from DEPTH-1 to 0. A master non-acknowledge ends the read.
- R5: Data bytes of a page write go to consecutive addresses. The offset within the PAGE-aligned page wraps, so the bytes stay in the page of the first byte.
- R6: A write is committed only if the stop arrives after whole 9-clock frames (the stop's own clock pulse is the first of a new frame). A stop that arrives part way through a byte discards the whole pending write and starts no write cycle.
- R7: A committed write starts a cycle of WRITE_CYCLES clocks. During that cycle every control byte is left unacknowledged, and after it ends the control byte is acknowledged again.
- R8: While `wr_en_i` is low, data bytes of a write sequence are not acknowledged and nothing is written.
- R9: If `wr_en_i` falls during the write cycle, the cycle ends at once, the array is left unchanged, and the block acknowledges its address again.
- R10: Writing one byte {en, bound[6:0]} with control code 4'b1011 sets the protection byte, which is applied at a valid stop. A bound below DEPTH/2 is raised to DEPTH/2. The byte reads back through a read with code 4'b1011. While en=1, array bytes at addresses >= bound are not written.
- R11: During read data the block changes the data line only while the clock is low, and it releases the line for the master's acknowledge bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Resolved bus data line level |
| wr_en_i | input | 1 | High allows writes; low rejects write data and aborts a running write cycle |
| sda_drive_o | output | 1 | High pulls the data line low; low releases it |

## Verification
The slave's output for a bit is due about four system clocks after the bus clock falls: two synchroniser stages, the edge detector and the drive register. This holds for the acknowledge and for read-data bits alike. The bench holds each bus clock quarter for six system clocks and samples the line in the middle of the high phase, so every acknowledge and read bit it records has been settled for several cycles. The write cycle lasts WRITE_CYCLES clocks from the stop. The bench therefore polls right after a write to see the missing acknowledge, and waits longer than the cycle before any read that checks written data.

// File: rtl/e2_guard_pkg.sv
package e2_guard_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_DEV, PH_WADDR, PH_WDATA, PH_PDATA, PH_RDATA, PH_RPROT, PH_SKIP
  } phase_e;

  localparam logic [3:0] MEM_CODE  = 4'b1010;
  localparam logic [3:0] PROT_CODE = 4'b1011;
endpackage

// File: rtl/e2_line_sync.sv
module e2_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [2:0] scl_sh, sda_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
    end
  end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now = scl_sh[1];
  assign scl_old = scl_sh[2];
  assign sda_now = sda_sh[1];
  assign sda_old = sda_sh[2];

  assign sda_o      = sda_now;
  assign scl_rise_o = scl_now & ~scl_old;
  assign scl_fall_o = ~scl_now & scl_old;
  assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/e2_write_timer.sv
module e2_write_timer #(
  parameter int CYCLES = 1200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q && abort_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q && start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0) && !abort_i;
endmodule

// File: rtl/e2_byte_array.sv
module e2_byte_array #(
  parameter int DEPTH = 128,
  parameter int PAGE  = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            commit_i,
  input  logic [$clog2(DEPTH)-$clog2(PAGE)-1:0] base_i,
  input  logic [PAGE-1:0][7:0]            data_i,
  input  logic [PAGE-1:0]                 mask_i,
  input  logic                            guard_en_i,
  input  logic [6:0]                      guard_bound_i,
  input  logic [$clog2(DEPTH)-1:0]        rd_addr_i,
  output logic [7:0]                      rd_data_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(PAGE);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] slot_addr [PAGE];
  logic [PAGE-1:0] slot_ok;

  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    assign slot_addr[g] = {base_i, PW'(g)};
    // protected region is the upper part, from the boundary up
    assign slot_ok[g] = mask_i[g] &&
                        !(guard_en_i && (32'(slot_addr[g]) >= 32'(guard_bound_i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit_i) begin
      for (int i = 0; i < PAGE; i++)
        if (slot_ok[i]) mem[slot_addr[i]] <= data_i[i];
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/e2_write_guard.sv
module e2_write_guard
  import e2_guard_pkg::*;
#(
  parameter int         DEPTH        = 128,
  parameter int         PAGE         = 16,
  parameter int         WRITE_CYCLES = 1200,
  parameter logic [2:0] DEV_SEL      = 3'b000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wr_en_i,
  output logic sda_drive_o
);
  localparam int AW   = $clog2(DEPTH);
  localparam int PW   = $clog2(PAGE);
  localparam int BW   = AW - PW;
  localparam int HALF = DEPTH / 2;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, wr_done, wr_start;

  phase_e               phase_q;
  logic [3:0]           bit_idx_q;
  logic [7:0]           shreg_q, tx_q;
  logic                 drive_q, acked_q, m_ack_q, ack_ok_q;
  logic [AW-1:0]        ptr_q;
  logic [PAGE-1:0][7:0] pg_buf_q;
  logic [PAGE-1:0]      pg_mask_q;
  logic [BW-1:0]        pg_base_q;
  logic [7:0]           prot_new_q;
  logic                 prot_pend_q, prot_en_q;
  logic [6:0]           prot_bound_q;
  logic [7:0]           rd_data, prot_byte;

  e2_line_sync u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  e2_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(wr_start), .abort_i(!wr_en_i),
    .busy_o(busy), .done_o(wr_done)
  );

  e2_byte_array #(.DEPTH(DEPTH), .PAGE(PAGE)) u_array (
    .clk_i, .rst_ni, .commit_i(wr_done), .base_i(pg_base_q),
    .data_i(pg_buf_q), .mask_i(pg_mask_q),
    .guard_en_i(prot_en_q), .guard_bound_i(prot_bound_q),
    .rd_addr_i(ptr_q), .rd_data_o(rd_data)
  );

  logic hit_mem, hit_prot, dev_ack, valid_end;
  logic [2:0] tx_sel;

  always_comb begin
    hit_mem   = (shreg_q[7:4] == MEM_CODE)  && (shreg_q[3:1] == DEV_SEL);
    hit_prot  = (shreg_q[7:4] == PROT_CODE) && (shreg_q[3:1] == DEV_SEL);
    dev_ack   = (hit_mem || hit_prot) && !busy;
    // stop clock pulse counts as bit 1 of a fresh frame
    valid_end = (bit_idx_q == 4'd1) && ack_ok_q && wr_en_i && !busy;
    tx_sel    = 3'd7 - bit_idx_q[2:0];
    prot_byte = {prot_en_q, prot_bound_q};
  end

  assign wr_start    = stop_det && valid_end && (|pg_mask_q);
  assign sda_drive_o = drive_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q      <= PH_IDLE;
      bit_idx_q    <= '0;
      shreg_q      <= '0;
      tx_q         <= '0;
      drive_q      <= 1'b0;
      acked_q      <= 1'b0;
      m_ack_q      <= 1'b0;
      ack_ok_q     <= 1'b0;
      ptr_q        <= '0;
      pg_buf_q     <= '0;
      pg_mask_q    <= '0;
      pg_base_q    <= '0;
      prot_new_q   <= '0;
      prot_pend_q  <= 1'b0;
      prot_en_q    <= 1'b0;
      prot_bound_q <= 7'(HALF);
    end else if (start_det) begin
      phase_q   <= PH_DEV;
      bit_idx_q <= '0;
      drive_q   <= 1'b0;
      ack_ok_q  <= 1'b1;
      if (!busy) begin
        pg_mask_q   <= '0;
        prot_pend_q <= 1'b0;
      end
    end else if (stop_det) begin
      phase_q   <= PH_IDLE;
      bit_idx_q <= '0;
      drive_q   <= 1'b0;
      if (valid_end && prot_pend_q) begin
        prot_en_q    <= prot_new_q[7];
        prot_bound_q <= (prot_new_q[6:0] < 7'(HALF)) ? 7'(HALF) : prot_new_q[6:0];
      end
    end else if (phase_q != PH_IDLE) begin
      if (scl_rise) begin
        bit_idx_q <= bit_idx_q + 1'b1;
        if (bit_idx_q < 4'd8)  shreg_q <= {shreg_q[6:0], sda_s};
        if (bit_idx_q == 4'd8) m_ack_q <= !sda_s;
      end else if (scl_fall) begin
        if (bit_idx_q == 4'd8) begin
          unique case (phase_q)
            PH_DEV: begin
              drive_q <= dev_ack;
              acked_q <= dev_ack;
            end
            PH_WADDR: begin
              drive_q <= 1'b1;
              acked_q <= 1'b1;
              ptr_q   <= shreg_q[AW-1:0];
            end
            PH_WDATA, PH_PDATA: begin
              drive_q <= wr_en_i;
              acked_q <= wr_en_i;
              if (!wr_en_i) begin
                ack_ok_q <= 1'b0;
              end else if (phase_q == PH_WDATA) begin
                pg_buf_q[ptr_q[PW-1:0]]  <= shreg_q;
                pg_mask_q[ptr_q[PW-1:0]] <= 1'b1;
                pg_base_q                <= ptr_q[AW-1:PW];
                ptr_q <= {ptr_q[AW-1:PW], ptr_q[PW-1:0] + 1'b1};
              end else begin
                prot_new_q  <= shreg_q;
                prot_pend_q <= 1'b1;
              end
            end
            default: begin
              drive_q <= 1'b0;
              acked_q <= 1'b0;
            end
          endcase
        end else if (bit_idx_q == 4'd9) begin
          bit_idx_q <= '0;
          drive_q   <= 1'b0;
          unique case (phase_q)
            PH_DEV: begin
              if (!acked_q) phase_q <= PH_SKIP;
              else begin
                unique case ({hit_prot, shreg_q[0]})
                  2'b00: phase_q <= PH_WADDR;
                  2'b01: begin
                    phase_q <= PH_RDATA;
                    tx_q    <= rd_data;
                    drive_q <= !rd_data[7];
                    ptr_q   <= ptr_q + 1'b1;
                  end
                  2'b10: phase_q <= PH_PDATA;
                  default: begin
                    phase_q <= PH_RPROT;
                    tx_q    <= prot_byte;
                    drive_q <= !prot_byte[7];
                  end
                endcase
              end
            end
            PH_WADDR: phase_q <= PH_WDATA;
            PH_WDATA, PH_PDATA: if (!acked_q) phase_q <= PH_SKIP;
            PH_RDATA: begin
              if (m_ack_q) begin
                tx_q    <= rd_data;
                drive_q <= !rd_data[7];
                ptr_q   <= ptr_q + 1'b1;
              end else phase_q <= PH_SKIP;
            end
            PH_RPROT: begin
              if (m_ack_q) begin
                tx_q    <= prot_byte;
                drive_q <= !prot_byte[7];
              end else phase_q <= PH_SKIP;
            end
            default: ;
          endcase
        end else if (bit_idx_q != 4'd0) begin
          if (phase_q == PH_RDATA || phase_q == PH_RPROT)
            drive_q <= !tx_q[tx_sel];
        end
      end
    end
  end
endmodule

// File: rtl/e2_write_guard_chk.sv
module e2_write_guard_chk
  import e2_guard_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       sda_drive_o,
  input phase_e     phase_i,
  input logic [3:0] bit_idx_i,
  input logic       busy_i,
  input logic       stop_i,
  input logic       prot_en_i,
  input logic [6:0] prot_bound_i
);
  localparam int HALF = DEPTH / 2;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_IDLE) |-> !sda_drive_o);

  p_busy_no_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && phase_i == PH_DEV) |-> !sda_drive_o);

  p_cycle_from_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(stop_i));

  p_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !wr_en_i) |=> !busy_i);

  p_prot_floor_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_en_i |-> (32'(prot_bound_i) >= HALF));

  p_master_ack_free_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_i == PH_RDATA || phase_i == PH_RPROT) && bit_idx_i == 4'd9) |-> !sda_drive_o);
endmodule

bind e2_write_guard e2_write_guard_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .sda_drive_o(sda_drive_o),
  .phase_i(phase_q), .bit_idx_i(bit_idx_q), .busy_i(busy), .stop_i(stop_det),
  .prot_en_i(prot_en_q), .prot_bound_i(prot_bound_q)
);

// File: tb/e2_write_guard_test.sv
`timescale 1ns/1ps
module e2_write_guard_test;
  localparam int Q     = 6;
  localparam int WAITW = 1300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, wr_en = 1'b1;
  logic sda_drive, sda_line;

  int n_checks = 0;
  int n_errors = 0;

  string      exp_req_q[$];
  logic [7:0] exp_val_q[$];
  logic [7:0] obs_q[$];

  always #10 clk = ~clk;
  assign sda_line = m_sda & ~sda_drive;

  e2_write_guard uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .wr_en_i(wr_en), .sda_drive_o(sda_drive)
  );

  // monitor: pair observed bus results with expected items in order
  always @(negedge clk) begin
    if (exp_val_q.size() > 0 && obs_q.size() > 0) begin
      string      r;
      logic [7:0] e, a;
      r = exp_req_q.pop_front();
      e = exp_val_q.pop_front();
      a = obs_q.pop_front();
      n_checks++;
      if (a !== e) begin
        n_errors++;
        $display("FAIL %s: actual %02h expected %02h", r, a, e);
      end
    end
  end

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic expect_item(input string req, input logic [7:0] v);
    exp_req_q.push_back(req);
    exp_val_q.push_back(v);
  endtask

  task automatic bit_cycle(input logic b, output logic s);
    m_sda = b; qwait();
    m_scl = 1'b1; qwait();
    s = sda_line; qwait();
    m_scl = 1'b0; qwait();
  endtask

  task automatic bus_start();
    m_sda = 1'b1; qwait();
    m_scl = 1'b1; qwait();
    m_sda = 1'b0; qwait();
    m_scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qwait();
    m_scl = 1'b1; qwait();
    m_sda = 1'b1; qwait();
  endtask

  // observed ack is pushed as 8'h01 (ack) or 8'h00 (no ack)
  task automatic wr_byte(input logic [7:0] b, input bit exp_ack, input string req);
    logic s;
    expect_item(req, exp_ack ? 8'h01 : 8'h00);
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, s);
    obs_q.push_back({7'd0, ~s});
  endtask

  task automatic rd_byte(input logic [7:0] exp, input bit last, input string req);
    logic s;
    logic [7:0] v;
    expect_item(req, exp);
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      v[i] = s;
    end
    obs_q.push_back(v);
    bit_cycle(last, s);
  endtask

  task automatic wait_write();
    repeat (WAITW) @(negedge clk);
  endtask

  task automatic write_one(input logic [7:0] a, input logic [7:0] d, input string req);
    bus_start();
    wr_byte(8'hA0, 1'b1, req);
    wr_byte(a, 1'b1, req);
    wr_byte(d, 1'b1, req);
    bus_stop();
    wait_write();
  endtask

  task automatic set_ptr_read(input logic [7:0] a, input string req);
    bus_start();
    wr_byte(8'hA0, 1'b1, req);
    wr_byte(a, 1'b1, req);
    bus_start();
    wr_byte(8'hA1, 1'b1, req);
  endtask

  task automatic read_one(input logic [7:0] a, input logic [7:0] exp, input string req);
    set_ptr_read(a, req);
    rd_byte(exp, 1'b1, req);
    bus_stop();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual run still busy, expected finish");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: line released after reset
    n_checks++;
    if (sda_drive !== 1'b0) begin
      n_errors++;
      $display("FAIL R1: actual drive %b expected 0", sda_drive);
    end

    // R2: foreign code and foreign select left without ack
    bus_start(); wr_byte(8'hE0, 1'b0, "R2"); bus_stop();
    bus_start(); wr_byte(8'hA2, 1'b0, "R2"); bus_stop();

    // R1/R5: page write at 0x10, then R7: poll during write cycle
    bus_start();
    wr_byte(8'hA0, 1'b1, "R1");
    wr_byte(8'h10, 1'b1, "R5");
    wr_byte(8'hD0, 1'b1, "R5");
    wr_byte(8'hD1, 1'b1, "R5");
    wr_byte(8'hD2, 1'b1, "R5");
    wr_byte(8'hD3, 1'b1, "R5");
    bus_stop();
    bus_start(); wr_byte(8'hA0, 1'b0, "R7"); bus_stop();
    wait_write();
    bus_start(); wr_byte(8'hA0, 1'b1, "R7"); bus_stop();

    // R3: random read of two bytes from 0x11
    set_ptr_read(8'h11, "R3");
    rd_byte(8'hD1, 1'b0, "R3");
    rd_byte(8'hD2, 1'b1, "R3");
    bus_stop();

    // R5: write from 0x1E wraps to 0x10 inside the page
    bus_start();
    wr_byte(8'hA0, 1'b1, "R5");
    wr_byte(8'h1E, 1'b1, "R5");
    wr_byte(8'hE1, 1'b1, "R5");
    wr_byte(8'hE2, 1'b1, "R5");
    wr_byte(8'hE3, 1'b1, "R5");
    bus_stop();
    wait_write();
    set_ptr_read(8'h10, "R5");
    rd_byte(8'hE3, 1'b0, "R5");
    rd_byte(8'hD1, 1'b1, "R5");
    bus_stop();
    set_ptr_read(8'h1E, "R5");
    rd_byte(8'hE1, 1'b0, "R5");
    rd_byte(8'hE2, 1'b1, "R5");
    bus_stop();

    // R4: sequential read wraps from the last address to 0
    write_one(8'h7F, 8'h5A, "R4");
    write_one(8'h00, 8'hA5, "R4");
    set_ptr_read(8'h7F, "R4");
    rd_byte(8'h5A, 1'b0, "R4");
    rd_byte(8'hA5, 1'b1, "R4");
    bus_stop();

    // R6: stop three bits into a byte discards the write
    bus_start();
    wr_byte(8'hA0, 1'b1, "R6");
    wr_byte(8'h40, 1'b1, "R6");
    wr_byte(8'h77, 1'b1, "R6");
    begin
      logic s;
      for (int i = 0; i < 3; i++) bit_cycle(1'b1, s);
    end
    bus_stop();
    bus_start(); wr_byte(8'hA0, 1'b1, "R6"); bus_stop();
    read_one(8'h40, 8'h00, "R6");

    // R8: write enable low rejects data
    wr_en = 1'b0;
    bus_start();
    wr_byte(8'hA0, 1'b1, "R8");
    wr_byte(8'h41, 1'b1, "R8");
    wr_byte(8'h55, 1'b0, "R8");
    bus_stop();
    wr_en = 1'b1;
    bus_start(); wr_byte(8'hA0, 1'b1, "R8"); bus_stop();
    read_one(8'h41, 8'h00, "R8");

    // R9: dropping write enable mid cycle aborts it
    bus_start();
    wr_byte(8'hA0, 1'b1, "R9");
    wr_byte(8'h42, 1'b1, "R9");
    wr_byte(8'h99, 1'b1, "R9");
    bus_stop();
    repeat (50) @(negedge clk);
    wr_en = 1'b0;
    repeat (10) @(negedge clk);
    wr_en = 1'b1;
    bus_start(); wr_byte(8'hA0, 1'b1, "R9"); bus_stop();
    read_one(8'h42, 8'h00, "R9");

    // R10: bound 0x20 raised to 0x40, readback {1,0x40}
    bus_start();
    wr_byte(8'hB0, 1'b1, "R10");
    wr_byte(8'hA0, 1'b1, "R10");
    bus_stop();
    bus_start();
    wr_byte(8'hB1, 1'b1, "R10");
    rd_byte(8'hC0, 1'b1, "R10");
    bus_stop();
    write_one(8'h50, 8'h34, "R10");
    write_one(8'h3F, 8'h12, "R10");
    read_one(8'h3F, 8'h12, "R10");
    read_one(8'h50, 8'h00, "R10");

    // R11: line released for master ack, so read of 0x00 then 0x01 stays in step
    set_ptr_read(8'h00, "R11");
    rd_byte(8'hA5, 1'b0, "R11");
    rd_byte(8'h00, 1'b1, "R11");
    bus_stop();

    repeat (20) @(negedge clk);
    if (exp_val_q.size() != 0) begin
      n_errors++;
      $display("FAIL scoreboard: actual %0d items left, expected 0", exp_val_q.size());
    end
    finish_run();
  end
endmodule